// File: doc/BRIEF.md
# Offline LED Start-Up Sequencer

This block orders the power-up of a mains-powered, dimmable LED driver. It stays idle until the supply-good flag rises with no undervoltage flag present. It then holds the boost switch on while it watches the AC line. The first half-cycle pulse it sees synchronises it. Over the next four half cycles it measures the line period in clock counts and works out which kind of phase-cut dimmer feeds the line.

After that it releases the boost hold and waits for the output to climb above the LED string forward voltage, then moves into constant-current operation. From the moment detection finishes, it publishes a pulse-width ceiling for the flyback switch. The ceiling starts small and rises by a fixed step on every switching cycle until it reaches full width. An undervoltage flag at any time throws everything back to the idle state, and the whole sequence then runs again.

Mode encoding on `mode_o`: 0 idle, 1 detect, 2 wait-for-output, 3 constant current.

Top module: `led_start_seq`

## Requirements
- R1: After reset the outputs are mode 0, boost hold low, ceiling 0, line period 0 and dimmer code 0.
- R2: In mode 0, a clock edge that samples `vcc_good_i` high with `vcc_uv_i` low moves the block to mode 1 on the next cycle. With `vcc_uv_i` high it stays in mode 0.
- R3: `boost_hold_o` is high for exactly as long as the mode is 1. Mode 1 ends at the edge that samples the fourth `half_cycle_i` pulse after the first one (the sync pulse) seen in mode 1. An `out_above_vf_i` seen in mode 1 has no effect.
- R4: An interval is the number of clocks from one sampled `half_cycle_i` pulse to the next, clipped at 2^LP_W-1. On leaving mode 1, `line_period_o` becomes the floor of the sum of the four intervals divided by four. It holds that value until an undervoltage event.
- R5: On leaving mode 1, `dimmer_o` is set from the four measured half cycles. It is 2 (leading edge) if `rise_step_i` was seen, otherwise 1 (trailing edge) if `fall_step_i` was seen, otherwise 0. A rising step wins when both were seen.
- R6: Step indications sampled in mode 1 before the sync pulse do not affect `dimmer_o`.
- R7: Mode 2 moves to mode 3 at the edge that samples `out_above_vf_i` high. Mode 3 is kept whatever `out_above_vf_i` does afterwards.
- R8: `pw_limit_o` is 0 in modes 0 and 1, and `sw_cycle_i` does not change it there. It loads PW_START on entry to mode 2. In modes 2 and 3, each sampled `sw_cycle_i` adds PW_STEP, clamped at PW_MAX.
- R9: A sampled `vcc_uv_i` in any mode gives mode 0 on the next cycle, with the ceiling, line period and dimmer code cleared. A later enable runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vcc_good_i | input | 1 | Supply above start-up threshold |
| vcc_uv_i | input | 1 | Supply below undervoltage threshold |
| half_cycle_i | input | 1 | One-clock pulse at each AC half-cycle start |
| rise_step_i | input | 1 | Sharp rising line step seen |
| fall_step_i | input | 1 | Sharp falling line step seen |
| out_above_vf_i | input | 1 | Output voltage above LED forward voltage |
| sw_cycle_i | input | 1 | One-clock pulse per switching cycle |
| boost_hold_o | output | 1 | Boost switch forced on |
| mode_o | output | 2 | Sequencer mode |
| pw_limit_o | output | PW_W | Pulse-width ceiling |
| line_period_o | output | LP_W | Averaged half-cycle period in clocks |
| dimmer_o | output | 2 | Dimmer code |

## Verification
The bench builds the block with LP_W=10, so a single long half cycle reaches the 1023 clip within a few thousand clocks. That lets the averaging of a clipped interval be checked alongside ordinary random intervals. The soft-start parameters are PW_START=5, PW_STEP=7 and PW_MAX=200. Because 200 is not reachable by whole steps from 5, the final step has to clamp rather than land exactly on the maximum, and about thirty switching pulses expose both the ramp and the clamp.

// File: rtl/led_start_pkg.sv
package led_start_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_DETECT = 2'd1,
    MODE_WAIT   = 2'd2,
    MODE_CC     = 2'd3
  } seq_mode_e;

  typedef enum logic [1:0] {
    DIM_NONE  = 2'd0,
    DIM_TRAIL = 2'd1,
    DIM_LEAD  = 2'd2
  } dimmer_e;
endpackage

// File: rtl/lss_period_meter.sv
module lss_period_meter #(
  parameter int LP_W   = 16,
  parameter int N_HALF = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            run_i,
  input  logic            half_cycle_i,
  output logic            counting_o,
  output logic            done_o,
  output logic [LP_W-1:0] period_o
);
  localparam int SHIFT = $clog2(N_HALF);
  localparam int CNT_W = $clog2(N_HALF + 1);
  localparam int SUM_W = LP_W + SHIFT;
  localparam logic [LP_W-1:0] TMR_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [LP_W-1:0]  tmr_q;
  logic [SUM_W-1:0] sum_q;
  logic [SUM_W-1:0] sum_fin;

  assign counting_o = (cnt_q != '0);
  assign done_o     = run_i && half_cycle_i && (cnt_q == CNT_W'(N_HALF));
  assign sum_fin    = sum_q + SUM_W'(tmr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tmr_q <= '0;
      sum_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
      tmr_q <= '0;
      sum_q <= '0;
    end else if (half_cycle_i) begin
      if (cnt_q == '0) begin
        cnt_q <= CNT_W'(1);
        sum_q <= '0;
        tmr_q <= LP_W'(1);
      end else if (cnt_q != CNT_W'(N_HALF)) begin
        cnt_q <= cnt_q + CNT_W'(1);
        sum_q <= sum_fin;
        tmr_q <= LP_W'(1);
      end
    end else if (counting_o && tmr_q != TMR_MAX) begin
      tmr_q <= tmr_q + LP_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     period_o <= '0;
    else if (clr_i)  period_o <= '0;
    else if (done_o) period_o <= LP_W'(sum_fin >> SHIFT);
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(N_HALF));

  // R4
  period_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !done_o) |=> $stable(period_o));
endmodule

// File: rtl/lss_dimmer_detect.sv
module lss_dimmer_detect
  import led_start_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    clr_i,
  input  logic    run_i,
  input  logic    counting_i,
  input  logic    done_i,
  input  logic    rise_step_i,
  input  logic    fall_step_i,
  output dimmer_e dimmer_o
);
  logic rise_q, fall_q;
  logic rise_any, fall_any;

  assign rise_any = rise_q || (counting_i && rise_step_i);
  assign fall_any = fall_q || (counting_i && fall_step_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (clr_i || !run_i || done_i) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= rise_any;
      fall_q <= fall_any;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dimmer_o <= DIM_NONE;
    else if (clr_i)   dimmer_o <= DIM_NONE;
    else if (done_i)  dimmer_o <= rise_any ? DIM_LEAD : (fall_any ? DIM_TRAIL : DIM_NONE);
  end

  // R6
  no_early_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!counting_i && !clr_i) |=> (!rise_q && !fall_q));
endmodule

// File: rtl/lss_soft_start.sv
module lss_soft_start #(
  parameter int PW_W     = 10,
  parameter int PW_START = 16,
  parameter int PW_STEP  = 8,
  parameter int PW_MAX   = 1000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            load_i,
  input  logic            run_i,
  input  logic            tick_i,
  output logic [PW_W-1:0] pw_o
);
  localparam logic [PW_W:0]   MAX_X   = (PW_W+1)'(PW_MAX);
  localparam logic [PW_W-1:0] MAX_V   = PW_W'(PW_MAX);
  localparam logic [PW_W-1:0] START_V = (PW_START > PW_MAX) ? PW_W'(PW_MAX) : PW_W'(PW_START);

  logic [PW_W-1:0] pw_next;

  generate
    if (PW_STEP >= PW_MAX) begin : g_jump
      assign pw_next = MAX_V;
    end else begin : g_ramp
      logic [PW_W:0] sum_x;
      assign sum_x   = {1'b0, pw_o} + (PW_W+1)'(PW_STEP);
      assign pw_next = (sum_x > MAX_X) ? MAX_V : sum_x[PW_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pw_o <= '0;
    else if (clr_i)           pw_o <= '0;
    else if (load_i)          pw_o <= START_V;
    else if (run_i && tick_i) pw_o <= pw_next;
  end

  // R8
  pw_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pw_o <= MAX_V);

  // R8
  pw_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i && !load_i) |=> pw_o >= $past(pw_o));
endmodule

// File: rtl/led_start_seq.sv
module led_start_seq
  import led_start_pkg::*;
#(
  parameter int LP_W     = 16,
  parameter int N_HALF   = 4,
  parameter int PW_W     = 10,
  parameter int PW_START = 16,
  parameter int PW_STEP  = 8,
  parameter int PW_MAX   = 1000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vcc_good_i,
  input  logic            vcc_uv_i,
  input  logic            half_cycle_i,
  input  logic            rise_step_i,
  input  logic            fall_step_i,
  input  logic            out_above_vf_i,
  input  logic            sw_cycle_i,
  output logic            boost_hold_o,
  output logic [1:0]      mode_o,
  output logic [PW_W-1:0] pw_limit_o,
  output logic [LP_W-1:0] line_period_o,
  output logic [1:0]      dimmer_o
);
  seq_mode_e mode_q, mode_d;
  logic      detecting, ramping, counting, det_done;
  dimmer_e   dim;

  assign detecting = (mode_q == MODE_DETECT);
  assign ramping   = (mode_q == MODE_WAIT) || (mode_q == MODE_CC);

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_OFF:    if (vcc_good_i) mode_d = MODE_DETECT;
      MODE_DETECT: if (det_done)   mode_d = MODE_WAIT;
      MODE_WAIT:   if (out_above_vf_i) mode_d = MODE_CC;
      MODE_CC:     mode_d = MODE_CC;
      default:     mode_d = MODE_OFF;
    endcase
    if (vcc_uv_i) mode_d = MODE_OFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_OFF;
    else         mode_q <= mode_d;
  end

  lss_period_meter #(.LP_W(LP_W), .N_HALF(N_HALF)) u_meter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (vcc_uv_i),
    .run_i        (detecting),
    .half_cycle_i (half_cycle_i),
    .counting_o   (counting),
    .done_o       (det_done),
    .period_o     (line_period_o)
  );

  lss_dimmer_detect u_dimmer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (vcc_uv_i),
    .run_i       (detecting),
    .counting_i  (counting),
    .done_i      (det_done),
    .rise_step_i (rise_step_i),
    .fall_step_i (fall_step_i),
    .dimmer_o    (dim)
  );

  lss_soft_start #(
    .PW_W(PW_W), .PW_START(PW_START), .PW_STEP(PW_STEP), .PW_MAX(PW_MAX)
  ) u_soft (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (vcc_uv_i),
    .load_i (det_done && !vcc_uv_i),
    .run_i  (ramping),
    .tick_i (sw_cycle_i),
    .pw_o   (pw_limit_o)
  );

  assign boost_hold_o = detecting;
  assign mode_o       = mode_q;
  assign dimmer_o     = dim;

  // R9
  uv_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcc_uv_i |=> (mode_o == 2'd0 && pw_limit_o == '0 && line_period_o == '0 && dimmer_o == 2'd0));

  // R2
  off_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_OFF) |=> (mode_q == MODE_OFF || mode_q == MODE_DETECT));

  // R7
  cc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_CC && !vcc_uv_i) |=> mode_q == MODE_CC);

  // R3
  boost_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(boost_hold_o) |-> (mode_q == MODE_WAIT || mode_q == MODE_OFF));
endmodule

// File: tb/tb_led_start_seq.sv
module tb_led_start_seq;
  localparam int LP_W = 10, N_HALF = 4, PW_W = 8;
  localparam int PW_START = 5, PW_STEP = 7, PW_MAX = 200;
  localparam int LP_SAT = (1 << LP_W) - 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic vcc_good_i = 0, vcc_uv_i = 0, half_cycle_i = 0, rise_step_i = 0;
  logic fall_step_i = 0, out_above_vf_i = 0, sw_cycle_i = 0;
  logic            boost_hold_o;
  logic [1:0]      mode_o, dimmer_o;
  logic [PW_W-1:0] pw_limit_o;
  logic [LP_W-1:0] line_period_o;

  int checks = 0, failures = 0;
  bit finished = 0;
  int pw_cnt;

  always #5 clk_i = ~clk_i;

  led_start_seq #(.LP_W(LP_W), .N_HALF(N_HALF), .PW_W(PW_W), .PW_START(PW_START),
                  .PW_STEP(PW_STEP), .PW_MAX(PW_MAX)) dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_period(int k0, int k1, int k2, int k3);
    int s = 0;
    int k[4] = '{k0, k1, k2, k3};
    foreach (k[i]) s += (k[i] > LP_SAT) ? LP_SAT : k[i];
    return s / 4;
  endfunction

  function automatic int exp_dim(bit r, bit f);
    return r ? 2 : (f ? 1 : 0);
  endfunction

  function automatic int exp_pw(int n);
    int v = PW_START + n * PW_STEP;
    return (v > PW_MAX) ? PW_MAX : v;
  endfunction

  task automatic cyc(bit g, bit uv, bit hc, bit rs, bit fs, bit ov, bit sw);
    vcc_good_i = g; vcc_uv_i = uv; half_cycle_i = hc; rise_step_i = rs;
    fall_step_i = fs; out_above_vf_i = ov; sw_cycle_i = sw;
    @(negedge clk_i);
  endtask

  task automatic enable();
    cyc(1, 0, 0, 0, 0, 0, 0);
    chk("R2 enter detect", mode_o, 1);
    chk("R3 boost on in detect", boost_hold_o, 1);
  endtask

  // one half cycle of k clocks ending in a pulse; optional step on its first clock
  task automatic half(int k, bit rs, bit fs, bit last);
    for (int j = 0; j < k - 1; j++) cyc(1, 0, 0, rs && j == 0, fs && j == 0, 0, 0);
    if (!last) begin
      cyc(1, 0, 1, 0, 0, 0, 0);
      chk("R3 boost held", boost_hold_o, 1);
    end else begin
      cyc(1, 0, 1, 0, 0, 0, 0);
    end
  endtask

  task automatic detect(int k0, int k1, int k2, int k3, bit r, bit f);
    cyc(1, 0, 0, 0, 0, 1, 1);
    chk("R8 sw ignored in detect", pw_limit_o, 0);
    chk("R3 vf ignored in detect", mode_o, 1);
    cyc(1, 0, 1, 0, 0, 0, 0);  // sync
    half(k0, r, 0, 0);
    half(k1, 0, f, 0);
    half(k2, 0, 0, 0);
    half(k3, 0, 0, 1);
    chk("R3 detect over", mode_o, 2);
    chk("R3 boost released", boost_hold_o, 0);
    chk("R4 line period", line_period_o, exp_period(k0, k1, k2, k3));
    chk("R5 dimmer code", dimmer_o, exp_dim(r, f));
    chk("R8 ceiling start", pw_limit_o, PW_START);
  endtask

  task automatic ramp(int n);
    for (int j = 0; j < n; j++) begin
      cyc(1, 0, 0, 0, 0, 0, 1);
      pw_cnt++;
    end
    chk("R8 ceiling ramp", pw_limit_o, exp_pw(pw_cnt));
  endtask

  task automatic uv_clear();
    cyc(1, 1, 0, 0, 0, 0, 0);
    chk("R9 uv mode", mode_o, 0);
    chk("R9 uv ceiling", pw_limit_o, 0);
    chk("R9 uv period", line_period_o, 0);
    chk("R9 uv dimmer", dimmer_o, 0);
    chk("R9 uv boost", boost_hold_o, 0);
  endtask

  task automatic episode(int k0, int k1, int k2, int k3, bit r, bit f, int n1, int n2);
    enable();
    detect(k0, k1, k2, k3, r, f);
    pw_cnt = 0;
    ramp(n1);
    cyc(1, 0, 0, 0, 0, 0, 0);
    chk("R7 wait holds", mode_o, 2);
    cyc(1, 0, 0, 0, 0, 1, 0);
    chk("R7 enter cc", mode_o, 3);
    cyc(1, 0, 0, 0, 0, 0, 0);
    chk("R7 cc kept", mode_o, 3);
    chk("R4 period held", line_period_o, exp_period(k0, k1, k2, k3));
    ramp(n2);
    uv_clear();
  endtask

  initial begin
    int seed = 17;
    void'($urandom(seed));
    @(negedge clk_i);
    chk("R1 reset mode", mode_o, 0);
    chk("R1 reset boost", boost_hold_o, 0);
    chk("R1 reset ceiling", pw_limit_o, 0);
    chk("R1 reset period", line_period_o, 0);
    chk("R1 reset dimmer", dimmer_o, 0);
    rst_ni = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R2 idle without good", mode_o, 0);
    cyc(1, 1, 0, 0, 0, 0, 0);
    chk("R2 uv blocks enable", mode_o, 0);

    // directed: rise step before sync is ignored, fall wins none
    enable();
    cyc(1, 0, 0, 1, 0, 0, 0);
    chk("R6 early step no effect", mode_o, 1);
    detect(40, 40, 40, 40, 0, 0);
    chk("R6 early step ignored", dimmer_o, 0);
    uv_clear();

    // directed: uv mid-detect, then restart
    enable();
    cyc(1, 0, 1, 0, 0, 0, 0);
    half(30, 0, 0, 0);
    uv_clear();
    episode(10, 12, 14, 16, 1, 1, 0, 40);  // both steps: leading wins, ceiling clamps
    episode(1500, 10, 10, 10, 0, 1, 3, 2); // clipped interval

    for (int e = 0; e < 6; e++) begin
      episode(2 + $urandom_range(0, 200), 2 + $urandom_range(0, 200),
              2 + $urandom_range(0, 200), 2 + $urandom_range(0, 200),
              $urandom_range(0, 1), $urandom_range(0, 1),
              $urandom_range(0, 15), $urandom_range(0, 20));
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule